// File: doc/BRIEF.md
# Looping Sample Playback Voice

This block is one voice of a sample-based synthesizer. The audio rate is fixed by an external tick strobe. On each accepted tick the voice reads two neighbouring words from sample memory and blends them by the fractional part of a phase accumulator. It emits one signed audio value with a one-cycle valid strobe. It then moves the phase on by a pitch increment. Pitch is therefore set only by the size of the increment. The clock is never changed.

A note-on loads the per-voice settings: first and last sample address, an optional separate loop point, one-shot or repeating playback, a forward-only or bouncing loop, and the increment. While the voice plays, a hard-sync pulse from another oscillator restarts it at the first address, and a new increment can be loaded. A note-off either silences the voice at once or lets it leave its loop and run out to the last address. When the voice falls silent it raises a one-cycle done pulse. After that it keeps producing valid zero samples on each tick and makes no memory reads.

The sample memory port has a fixed read latency, set by a parameter. The voice issues exactly two reads per tick.

Top module: `smp_voice`

## Requirements
- R1: After reset, `out_valid`, `done`, `mem_rd_en` and `out_sample` are 0. A tick accepted while no note plays gives `out_valid` with `out_sample` 0, MEM_LAT+2 cycles after the tick edge, and no memory read.
- R2: `note_on` loads all `cfg_*` inputs and puts the phase at `cfg_start` with a zero fraction. For an accepted tick at clock edge T while the voice plays, `mem_rd_en` is high for exactly the two cycles after edges T and T+1. The first address is the integer part of the phase and the second is its neighbour. Each word is taken from `mem_rd_data` MEM_LAT edges after the edge that presents its read. The result appears with a one-cycle `out_valid` after edge T+MEM_LAT+2.
- R3: The phase is unsigned fixed point: ADDR_W integer bits above FRAC_W fraction bits. A tick adds the increment to it. The increment is latched at note-on, and `inc_load` replaces it. A replacement takes effect from the next tick advance onward.
- R4: The output is s0 + floor((s1 - s0) * frac / 2^FRAC_W), saturated to the signed DATA_W range. Here s0 is the word at the integer address, s1 is its neighbour, and both are two's complement.
- R5: A one-shot voice whose advanced phase would exceed `cfg_end` * 2^FRAC_W stops. It keeps its phase, goes silent, and pulses `done` for one cycle after that tick edge. Later ticks yield valid zeros with no reads.
- R6: In forward repeat mode, a phase that passes the end wraps to loop + (phase - end), so the overshoot is kept. The loop point is `cfg_lpt` when `cfg_lpt_use` is 1, otherwise `cfg_start`.
- R7: In bounce mode, passing the end gives end - overshoot and turns the voice downward. While going down, the phase falls by the increment. Passing below the loop point gives loop + undershoot and turns the voice upward. A reflected phase is clamped into [loop, end].
- R8: `hsync` while playing sets the phase to `cfg_start` with a zero fraction and the direction to upward. The priority is note-on, then note-off, then sync, then the tick advance.
- R9: `note_off` with `note_cut` = 1 silences a playing voice and pulses `done`. With `note_cut` = 0 the voice leaves repeat mode, turns upward, and stops later as in one-shot mode.
- R10: The neighbour address is integer+1, except when the integer part is at or beyond `cfg_end`. In that case the same address is read twice.
- R11: A tick that arrives before MEM_LAT+3 cycles have passed since the last accepted tick is ignored. It gives no output, no read and no phase advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| note_on | input | 1 | Start a note with the current settings |
| note_off | input | 1 | Release the note |
| note_cut | input | 1 | With note_off: silence at once |
| hsync | input | 1 | Hard-sync restart pulse |
| cfg_start | input | ADDR_W | First sample address |
| cfg_end | input | ADDR_W | Last sample address |
| cfg_lpt | input | ADDR_W | Separate loop point |
| cfg_lpt_use | input | 1 | Use cfg_lpt as the loop point |
| cfg_repeat | input | 1 | 1 = repeating, 0 = one-shot |
| cfg_bounce | input | 1 | 1 = alternate direction in the loop |
| cfg_inc | input | ADDR_W+FRAC_W | Phase increment per tick |
| inc_load | input | 1 | Replace the increment while playing |
| tick | input | 1 | Output sample-rate strobe |
| mem_rd_en | output | 1 | Sample memory read request |
| mem_rd_addr | output | ADDR_W | Sample memory read address |
| mem_rd_data | input | DATA_W | Read word, MEM_LAT cycles after the request |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DATA_W | Signed audio sample |
| done | output | 1 | One-cycle pulse when the voice goes silent |

## Verification
The bench keeps the default 20.12 phase and 16-bit samples, but builds the voice with MEM_LAT=3 instead of the default 2. This moves both capture windows and raises the minimum tick spacing to six cycles, so any hard-wired latency shows up as a timing mismatch. The modelled memory returns full-scale positive and negative words at neighbouring addresses, which exercises the widest interpolation difference. The wide address range lets every loop case sit in its own region. An increment larger than the loop span reaches the clamp of a reflected phase.

// File: rtl/smp_voice_pkg.sv
package smp_voice_pkg;
  // Travel direction of the read position inside a bouncing loop.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/smp_phase.sv
module smp_phase
  import smp_voice_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     note_on,
  input  logic                     note_off,
  input  logic                     note_cut,
  input  logic                     hsync,
  input  logic                     step,
  input  logic [ADDR_W-1:0]        cfg_start,
  input  logic [ADDR_W-1:0]        cfg_end,
  input  logic [ADDR_W-1:0]        cfg_lpt,
  input  logic                     cfg_lpt_use,
  input  logic                     cfg_repeat,
  input  logic                     cfg_bounce,
  input  logic [ADDR_W+FRAC_W-1:0] cfg_inc,
  input  logic                     inc_load,
  output logic [ADDR_W+FRAC_W-1:0] pos,
  output logic [ADDR_W-1:0]        end_addr,
  output logic                     active,
  output logic                     done
);
  localparam int ACC_W = ADDR_W + FRAC_W;
  localparam int EXT_W = ACC_W + 2;
  localparam logic [FRAC_W-1:0] FRAC_ZERO = '0;

  logic [ACC_W-1:0]  pos_q, inc_q;
  logic [ADDR_W-1:0] start_q, end_q, lp_q;
  logic              rep_q, bnc_q, act_q, done_q;
  dir_e              dir_q, ndir;

  logic signed [EXT_W-1:0] p_e, i_e, e_e, l_e, up_s, dn_s, np;
  logic                    bent, stop;

  // Next position: advance, then wrap, reflect or stop at the bounds.
  always_comb begin
    p_e  = $signed({2'b00, pos_q});
    i_e  = $signed({2'b00, inc_q});
    e_e  = $signed({2'b00, end_q, FRAC_ZERO});
    l_e  = $signed({2'b00, lp_q, FRAC_ZERO});
    up_s = p_e + i_e;
    dn_s = p_e - i_e;
    np   = up_s;
    ndir = dir_q;
    bent = 1'b0;
    stop = 1'b0;
    if (dir_q == DIR_UP) begin
      if (up_s > e_e) begin
        if (!rep_q) begin
          stop = 1'b1;
        end else if (bnc_q) begin
          np   = e_e + e_e - up_s;
          ndir = DIR_DOWN;
          bent = 1'b1;
        end else begin
          np   = l_e + (up_s - e_e);
          bent = 1'b1;
        end
      end
    end else begin
      np = dn_s;
      if (dn_s < l_e) begin
        np   = l_e + l_e - dn_s;
        ndir = DIR_UP;
        bent = 1'b1;
      end
    end
    if (bent) begin
      if (np > e_e)      np = e_e;
      else if (np < l_e) np = l_e;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      inc_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      lp_q    <= '0;
      rep_q   <= 1'b0;
      bnc_q   <= 1'b0;
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      dir_q   <= DIR_UP;
    end else begin
      done_q <= 1'b0;
      if (inc_load) inc_q <= cfg_inc;
      if (note_on) begin
        start_q <= cfg_start;
        end_q   <= cfg_end;
        lp_q    <= cfg_lpt_use ? cfg_lpt : cfg_start;
        rep_q   <= cfg_repeat;
        bnc_q   <= cfg_bounce;
        inc_q   <= cfg_inc;
        pos_q   <= {cfg_start, FRAC_ZERO};
        dir_q   <= DIR_UP;
        act_q   <= 1'b1;
      end else if (note_off && act_q) begin
        if (note_cut) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rep_q <= 1'b0;
          dir_q <= DIR_UP;
        end
      end else if (hsync && act_q) begin
        pos_q <= {start_q, FRAC_ZERO};
        dir_q <= DIR_UP;
      end else if (step && act_q) begin
        if (stop) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          pos_q <= np[ACC_W-1:0];
          dir_q <= ndir;
        end
      end
    end
  end

  assign pos      = pos_q;
  assign end_addr = end_q;
  assign active   = act_q;
  assign done     = done_q;

  // R5: the done strobe lasts a single cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R5 / R9: done is only raised by a voice that has gone silent
  a_r9_done_silent: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !act_q);
  // R7: a playing voice never sits beyond its last address
  a_r7_in_bounds: assert property (@(posedge clk) disable iff (rst)
    (act_q && (start_q <= end_q)) |-> (pos_q <= {end_q, FRAC_ZERO}));
  // R8: hard sync restarts at the first address
  a_r8_sync_restart: assert property (@(posedge clk) disable iff (rst)
    (hsync && act_q && !note_on && !note_off) |=> (pos_q == {start_q, FRAC_ZERO}));
endmodule

// File: rtl/smp_fetch.sv
module smp_fetch #(
  parameter int ADDR_W  = 20,
  parameter int FRAC_W  = 12,
  parameter int DATA_W  = 16,
  parameter int MEM_LAT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic                     go_mute,
  input  logic [ADDR_W+FRAC_W-1:0] go_pos,
  input  logic [ADDR_W-1:0]        go_end,
  output logic                     idle,
  output logic                     mem_rd_en,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic [DATA_W-1:0]        mem_rd_data,
  output logic                     mix_go,
  output logic                     mix_mute,
  output logic [DATA_W-1:0]        mix_s0,
  output logic [DATA_W-1:0]        mix_s1,
  output logic [FRAC_W-1:0]        mix_frac
);
  localparam int ACC_W = ADDR_W + FRAC_W;
  localparam int LAST  = MEM_LAT + 2;
  localparam int CNT_W = $clog2(LAST + 1);

  logic [CNT_W-1:0]  cnt;
  logic              mute_q;
  logic [FRAC_W-1:0] frac_q;
  logic [ADDR_W-1:0] nxt_q;
  logic [DATA_W-1:0] s0_q;
  logic [ADDR_W-1:0] go_int;
  logic [FRAC_W-1:0] go_frac;

  assign go_int  = go_pos[ACC_W-1:FRAC_W];
  assign go_frac = go_pos[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      mute_q      <= 1'b0;
      frac_q      <= '0;
      nxt_q       <= '0;
      s0_q        <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else if (cnt == '0) begin
      if (go) begin
        cnt         <= CNT_W'(1);
        mute_q      <= go_mute;
        frac_q      <= go_frac;
        nxt_q       <= (go_int >= go_end) ? go_int : go_int + ADDR_W'(1);
        mem_rd_en   <= !go_mute;
        mem_rd_addr <= go_int;
      end
    end else begin
      if (cnt == CNT_W'(1)) mem_rd_addr <= nxt_q;
      if (cnt == CNT_W'(2)) mem_rd_en <= 1'b0;
      if (cnt == CNT_W'(MEM_LAT + 1)) s0_q <= mem_rd_data;
      cnt <= (cnt == CNT_W'(LAST)) ? '0 : cnt + CNT_W'(1);
    end
  end

  assign idle     = (cnt == '0);
  assign mix_go   = (cnt == CNT_W'(LAST));
  assign mix_mute = mute_q;
  assign mix_s0   = s0_q;
  assign mix_s1   = mem_rd_data;
  assign mix_frac = frac_q;

  // R2: a read burst is exactly two cycles long
  a_r2_pair_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_en) |=> mem_rd_en);
  a_r2_pair_end: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en);
  // R10: the second read repeats the first address or steps by one
  a_r10_neighbour: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |->
      ((mem_rd_addr - $past(mem_rd_addr)) <= ADDR_W'(1)));
endmodule

// File: rtl/smp_interp.sv
module smp_interp #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mix_go,
  input  logic              mix_mute,
  input  logic [DATA_W-1:0] mix_s0,
  input  logic [DATA_W-1:0] mix_s1,
  input  logic [FRAC_W-1:0] mix_frac,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample
);
  localparam int PW = DATA_W + FRAC_W + 2;
  localparam logic signed [PW-1:0] SMAX = PW'(signed'((64'sd1 <<< (DATA_W - 1)) - 64'sd1));
  localparam logic signed [PW-1:0] SMIN = PW'(signed'(-(64'sd1 <<< (DATA_W - 1))));

  logic signed [DATA_W:0]   dif;
  logic signed [PW-1:0]     prod, shf, sum;
  logic        [DATA_W-1:0] sat;

  always_comb begin
    dif  = $signed({mix_s1[DATA_W-1], mix_s1}) - $signed({mix_s0[DATA_W-1], mix_s0});
    prod = dif * $signed({1'b0, mix_frac});
    shf  = prod >>> FRAC_W;
    sum  = $signed({{(FRAC_W + 2){mix_s0[DATA_W-1]}}, mix_s0}) + shf;
    if (sum > SMAX)      sat = SMAX[DATA_W-1:0];
    else if (sum < SMIN) sat = SMIN[DATA_W-1:0];
    else                 sat = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= mix_go;
      if (mix_go) out_sample <= mix_mute ? '0 : sat;
    end
  end

  // R4: the blend lies between its two taps
  a_r4_between_taps: assert property (@(posedge clk) disable iff (rst)
    (mix_go && !mix_mute) |=>
      (($signed(out_sample) >= $signed($past(mix_s0)) && $signed(out_sample) <= $signed($past(mix_s1))) ||
       ($signed(out_sample) <= $signed($past(mix_s0)) && $signed(out_sample) >= $signed($past(mix_s1)))));
  // R5: a silent voice emits zero
  a_r5_silent_zero: assert property (@(posedge clk) disable iff (rst)
    (mix_go && mix_mute) |=> (out_valid && out_sample == '0));
endmodule

// File: rtl/smp_voice.sv
module smp_voice #(
  parameter int ADDR_W  = 20,
  parameter int FRAC_W  = 12,
  parameter int DATA_W  = 16,
  parameter int MEM_LAT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     note_on,
  input  logic                     note_off,
  input  logic                     note_cut,
  input  logic                     hsync,
  input  logic [ADDR_W-1:0]        cfg_start,
  input  logic [ADDR_W-1:0]        cfg_end,
  input  logic [ADDR_W-1:0]        cfg_lpt,
  input  logic                     cfg_lpt_use,
  input  logic                     cfg_repeat,
  input  logic                     cfg_bounce,
  input  logic [ADDR_W+FRAC_W-1:0] cfg_inc,
  input  logic                     inc_load,
  input  logic                     tick,
  output logic                     mem_rd_en,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic [DATA_W-1:0]        mem_rd_data,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_sample,
  output logic                     done
);
  localparam int ACC_W = ADDR_W + FRAC_W;

  logic              fetch_idle, tick_ok, voice_act;
  logic [ACC_W-1:0]  cur_pos;
  logic [ADDR_W-1:0] cur_end;
  logic              mix_go, mix_mute;
  logic [DATA_W-1:0] mix_s0, mix_s1;
  logic [FRAC_W-1:0] mix_frac;

  // R11: ticks are only taken while the fetch sequencer is free
  assign tick_ok = tick & fetch_idle;

  smp_phase #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_phase (
    .clk(clk), .rst(rst),
    .note_on(note_on), .note_off(note_off), .note_cut(note_cut), .hsync(hsync),
    .step(tick_ok),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_lpt(cfg_lpt),
    .cfg_lpt_use(cfg_lpt_use), .cfg_repeat(cfg_repeat), .cfg_bounce(cfg_bounce),
    .cfg_inc(cfg_inc), .inc_load(inc_load),
    .pos(cur_pos), .end_addr(cur_end), .active(voice_act), .done(done)
  );

  smp_fetch #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) u_fetch (
    .clk(clk), .rst(rst),
    .go(tick_ok), .go_mute(!voice_act), .go_pos(cur_pos), .go_end(cur_end),
    .idle(fetch_idle),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mix_go(mix_go), .mix_mute(mix_mute), .mix_s0(mix_s0), .mix_s1(mix_s1),
    .mix_frac(mix_frac)
  );

  smp_interp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_interp (
    .clk(clk), .rst(rst),
    .mix_go(mix_go), .mix_mute(mix_mute), .mix_s0(mix_s0), .mix_s1(mix_s1),
    .mix_frac(mix_frac),
    .out_valid(out_valid), .out_sample(out_sample)
  );
endmodule

// File: tb/smp_voice_bench.sv
`timescale 1ns/1ps
module smp_voice_bench;
  localparam int AW = 20, FW = 12, DW = 16, LAT = 3;
  localparam int GAP = LAT + 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, note_on, note_off, note_cut, hsync, inc_load, tick;
  logic [AW-1:0] cfg_start, cfg_end, cfg_lpt;
  logic cfg_lpt_use, cfg_repeat, cfg_bounce;
  logic [AW+FW-1:0] cfg_inc;
  logic mem_rd_en, out_valid, done;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data, out_sample;

  smp_voice #(.ADDR_W(AW), .FRAC_W(FW), .DATA_W(DW), .MEM_LAT(LAT)) u_smp_voice (
    .clk(clk), .rst(rst), .note_on(note_on), .note_off(note_off), .note_cut(note_cut),
    .hsync(hsync), .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_lpt(cfg_lpt),
    .cfg_lpt_use(cfg_lpt_use), .cfg_repeat(cfg_repeat), .cfg_bounce(cfg_bounce),
    .cfg_inc(cfg_inc), .inc_load(inc_load), .tick(tick),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_sample(out_sample), .done(done)
  );

  // Sample memory contents, computed; full-scale words at addresses 5 and 6 mod 37.
  function automatic logic [DW-1:0] wd(longint a);
    longint m = a % 37;
    if (m == 5) return 16'h7FFF;
    if (m == 6) return 16'h8000;
    return 16'((a * 40503 + 977) ^ (a << 7));
  endfunction

  // Fixed-latency memory model.
  logic [AW-1:0] apipe [LAT];
  always @(posedge clk) begin
    apipe[0] <= mem_rd_addr;
    for (int i = 1; i < LAT; i++) apipe[i] <= apipe[i-1];
  end
  assign mem_rd_data = wd(longint'(apipe[LAT-1]));

  function automatic longint sx(logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint mix(longint s0, longint s1, longint f);
    longint r = s0 + (((s1 - s0) * f) >>> FW);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  task automatic check(string rq, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", rq, what, cyc, act, exp);
    end
  endtask

  // Behavioural reference model.
  longint m_pos, m_inc, m_s, m_e, m_l, busy_end, done_at;
  bit m_act, m_rep, m_bnc, m_down;
  longint exp_out [int];
  longint exp_rd  [int];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_act = 0; m_rep = 0; m_bnc = 0; m_down = 0;
      m_pos = 0; m_inc = 0; m_s = 0; m_e = 0; m_l = 0;
      busy_end = -100; done_at = -1;
    end else begin
      bit tk;
      tk = tick && (cyc > busy_end);          // R11
      if (tk) begin
        busy_end = cyc + LAT + 2;
        if (m_act) begin
          longint n, n1, f;
          n  = m_pos >> FW;
          f  = m_pos & ((64'd1 << FW) - 1);
          n1 = (n >= m_e) ? n : n + 1;        // R10
          exp_rd[cyc] = n;
          exp_rd[cyc+1] = n1;
          exp_out[cyc+LAT+2] = mix(sx(wd(n)), sx(wd(n1)), f);
        end else begin
          exp_out[cyc+LAT+2] = 0;
        end
      end
      if (note_on) begin
        m_s = cfg_start; m_e = cfg_end; m_l = cfg_lpt_use ? cfg_lpt : cfg_start;
        m_rep = cfg_repeat; m_bnc = cfg_bounce; m_pos = m_s << FW;
        m_down = 0; m_act = 1;
      end else if (note_off && m_act) begin
        if (note_cut) begin m_act = 0; done_at = cyc; end
        else begin m_rep = 0; m_down = 0; end
      end else if (hsync && m_act) begin
        m_pos = m_s << FW; m_down = 0;
      end else if (tk && m_act) begin
        longint ef, lf, np;
        bit refl;
        ef = m_e << FW; lf = m_l << FW; refl = 0;
        if (!m_down) begin
          np = m_pos + m_inc;
          if (np > ef) begin
            if (!m_rep) begin m_act = 0; done_at = cyc; np = m_pos; end
            else if (m_bnc) begin np = ef - (np - ef); m_down = 1; refl = 1; end
            else begin np = lf + (np - ef); refl = 1; end
          end
        end else begin
          np = m_pos - m_inc;
          if (np < lf) begin np = lf + (lf - np); m_down = 0; refl = 1; end
        end
        if (refl && np > ef) np = ef;
        if (refl && np < lf) np = lf;
        m_pos = np;
      end
      if (note_on || inc_load) m_inc = cfg_inc;   // R3
    end
  end

  // Compare on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      bit ev, er;
      ev = exp_out.exists(cyc);
      check(cur_req, "out_valid", longint'(out_valid), longint'(ev));
      if (ev && out_valid) check(cur_req, "out_sample", sx(out_sample), exp_out[cyc]);
      check(cur_req, "done", longint'(done), longint'(done_at == cyc));
      er = exp_rd.exists(cyc);
      check(cur_req, "mem_rd_en", longint'(mem_rd_en), longint'(er));
      if (er && mem_rd_en) check(cur_req, "mem_rd_addr", longint'(mem_rd_addr), exp_rd[cyc]);
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n, int gap);
    repeat (n) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      idle_n(gap - 1);
    end
  endtask

  task automatic start_note(int s, int e, int l, bit lu, bit rp, bit bn, int inc);
    cfg_start = AW'(s); cfg_end = AW'(e); cfg_lpt = AW'(l);
    cfg_lpt_use = lu; cfg_repeat = rp; cfg_bounce = bn; cfg_inc = (AW+FW)'(inc);
    note_on = 1'b1; @(negedge clk); note_on = 1'b0;
  endtask

  task automatic release_note(bit cut);
    note_off = 1'b1; note_cut = cut; @(negedge clk); note_off = 1'b0; note_cut = 1'b0;
  endtask

  initial begin
    rst = 1'b1; note_on = 0; note_off = 0; note_cut = 0; hsync = 0; inc_load = 0; tick = 0;
    cfg_start = '0; cfg_end = '0; cfg_lpt = '0; cfg_lpt_use = 0; cfg_repeat = 0; cfg_bounce = 0;
    cfg_inc = '0;
    idle_n(4);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "reset out_valid", longint'(out_valid), 0);
    check("R1", "reset done", longint'(done), 0);
    check("R1", "reset mem_rd_en", longint'(mem_rd_en), 0);
    check("R1", "reset out_sample", longint'(out_sample), 0);
    cur_req = "R1"; ticks(2, GAP);                                 // idle ticks give zeros
    cur_req = "R2"; start_note(100, 400, 0, 0, 0, 0, 32'h1000); ticks(3, GAP);
    cur_req = "R3"; start_note(100, 400, 0, 0, 0, 0, 32'h1800); ticks(4, GAP);
    cfg_inc = 32'h0A55; inc_load = 1'b1; @(negedge clk); inc_load = 1'b0; ticks(5, GAP);
    cur_req = "R4"; start_note(220, 240, 0, 0, 0, 0, 32'h0733); ticks(20, GAP);
    cur_req = "R10"; start_note(50, 56, 0, 0, 0, 0, 32'h2000); ticks(4, GAP);
    cur_req = "R5"; ticks(4, GAP);
    cur_req = "R6"; start_note(200, 230, 210, 1, 1, 0, 32'h3480); ticks(30, GAP);
    start_note(200, 212, 500, 0, 1, 0, 32'h1C00); ticks(20, GAP);
    cur_req = "R7"; start_note(300, 320, 305, 1, 1, 1, 32'h2C40); ticks(40, GAP);
    start_note(300, 320, 305, 1, 1, 1, 32'h1E000); ticks(12, GAP);
    cur_req = "R8"; start_note(400, 500, 0, 0, 1, 0, 32'h5000); ticks(5, GAP);
    hsync = 1'b1; @(negedge clk); hsync = 1'b0; ticks(5, GAP);
    start_note(700, 710, 702, 1, 1, 1, 32'h3000); ticks(8, GAP);
    hsync = 1'b1; @(negedge clk); hsync = 1'b0; ticks(4, GAP);
    cur_req = "R9"; start_note(600, 640, 610, 1, 1, 0, 32'h4000); ticks(8, GAP);
    release_note(1'b0); ticks(8, GAP);
    start_note(600, 640, 610, 1, 1, 1, 32'h4000); ticks(3, GAP);
    release_note(1'b1); ticks(3, GAP);
    cur_req = "R11"; start_note(800, 900, 0, 0, 1, 0, 32'h1400);
    tick = 1'b1; @(negedge clk); tick = 1'b0; idle_n(1);
    tick = 1'b1; @(negedge clk); tick = 1'b0; idle_n(GAP);
    ticks(3, GAP);
    idle_n(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule